// File: doc/BRIEF.md
# Data-Dependent Early-Exit Vector Sequencer

This block walks a vector operation one element per clock, from element 0 upwards, up to a length `vl_in` captured on `start`. The environment holds the operand storage: it watches `elem_idx` and returns that element's two operands and its summary-overflow flag in the same cycle. The block adds the two operands, or adds them with saturation, and builds a 4-bit condition field from the result. It then drives per-element write strobes for the result and for the condition field.

A 5-bit mode word picks the variant. In the early-exit variants, each element's condition field is tested. The first element that fails the test ends the loop at once, and the block reports a shortened length on `vl_out`. That length either excludes or includes the failing element. When condition writing is on, the failing element's condition field is still written. `done` pulses for one cycle when the walk ends, and `vl_out` holds its value until the next start.

Top module: `vff_seq`

## Requirements
- R1: Mode bit numbering is `mode[k]` = field bit k. With `mode[1]=0, mode[0]=1, mode[2]=0` the result is the unsigned sum clamped to 255 when it carries out of 8 bits.
- R2: With `mode[1]=0, mode[0]=1, mode[2]=1` the result is the signed sum clamped to +127 or -128 on overflow.
- R3: With `mode[1:0]=00`, or with `mode[1]=1`, the result is the 8-bit wrapping sum of the two operands.
- R4: `cr_out` is `{lt,gt,eq,so}` in bits 3..0. `eq` is set when the result is zero. `lt` is result bit 7. `gt` is set when neither `lt` nor `eq` is set. `so` is `so_in`.
- R5: When `mode[1]=1` and `rc=1`, the tested bit index is `{mode[3],mode[4]}` (0=lt, 1=gt, 2=eq, 3=so). The element fails when that bit equals `mode[2]`.
- R6: When `mode[1]=1` and `mode[0]=0`, a failing element at index i ends the loop, sets `vl_out` to i, and its result is not written.
- R7: When `mode[1]=1` and `mode[0]=1`, a failing element at index i ends the loop, sets `vl_out` to i+1, and its result is written.
- R8: With `rc=1`, `cr_we` is raised for every tested element, including the failing one.
- R9: When `mode[1]=1` and `rc=0`, `mode[4]=1` enables a zero test: the element fails when `eq` equals `mode[2]`, and `cr_we` is raised. With `mode[4]=0` no element fails and `cr_we` stays low.
- R10: Elements are presented in order, one per cycle, with `busy` high. With no failure, `vl_out` equals `vl_in`, and `done` is high for the single cycle after element `vl_in-1`.
- R11: A `vl_in` of 0 gives `done` in the cycle after `start`, with `vl_out` 0 and no write strobes. `done` never coincides with `busy` or with a write strobe.
- R12: When `mode[1]=0`, all `vl_in` elements run and no early exit happens.
- R13: `start`, `vl_in`, `mode` and `rc` are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a vector walk (accepted when idle) |
| vl_in | input | 7 | Requested vector length |
| mode | input | 5 | Variant select word |
| rc | input | 1 | Condition-field recording enable |
| op_a | input | 8 | First operand of element `elem_idx` |
| op_b | input | 8 | Second operand of element `elem_idx` |
| so_in | input | 1 | Summary-overflow flag of element `elem_idx` |
| busy | output | 1 | An element is being processed this cycle |
| elem_idx | output | 7 | Index of the current element |
| res_out | output | 8 | Result of the current element |
| res_we | output | 1 | Write strobe for `res_out` |
| cr_out | output | 4 | Condition field of the current element |
| cr_we | output | 1 | Write strobe for `cr_out` |
| vl_out | output | 7 | Final (possibly shortened) vector length |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
The bench sweeps all 32 mode words with both `rc` settings over five data patterns. The patterns place zeros, negatives, signed overflow and unsigned carry at known element positions. The lengths tried are 0, 1, 4, 9 and 20, plus the full 127. A design that mixed up the exclusive and inclusive truncation would report `vl_out` off by one and write the failing result, or drop it, against R6/R7. A design that gated the condition strobe with the failure would lose the failing element's condition field. Further runs catch a wrong bit-select order, which exits at the wrong element, and clamping that is missing or on the wrong side, which shows in `res_out`. Runs that wiggle `start` and the length mid-walk catch a design that re-latches them.

// File: rtl/vff_pkg.sv
package vff_pkg;

    localparam int CR_W = 4;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_SAT   = 2'd1,
        K_EXIT  = 2'd2
    } op_kind_t;

    typedef struct packed {
        op_kind_t   kind;
        logic       sat_signed;
        logic       keep_fail;   // inclusive truncation
        logic       invert;
        logic       test_en;
        logic [1:0] test_sel;    // 0=lt 1=gt 2=eq 3=so
        logic       cr_en;
    } ctl_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    function automatic logic pick_cond(cond_t c, logic [1:0] sel);
        logic r;
        case (sel)
            2'd0:    r = c.lt;
            2'd1:    r = c.gt;
            2'd2:    r = c.eq;
            default: r = c.so;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vff_decode.sv
module vff_decode
    import vff_pkg::*;
(
    input  logic [4:0] mode,
    input  logic       rc,
    output ctl_t       ctl
);
    always_comb begin
        ctl = '0;
        if (mode[1]) begin
            ctl.kind      = K_EXIT;
            ctl.keep_fail = mode[0];
            ctl.invert    = mode[2];
            if (rc) begin
                ctl.test_en  = 1'b1;
                ctl.test_sel = {mode[3], mode[4]};
            end else begin
                ctl.test_en  = mode[4];
                ctl.test_sel = 2'd2;
            end
            ctl.cr_en = rc | mode[4];
        end else begin
            ctl.kind       = mode[0] ? K_SAT : K_PLAIN;
            ctl.sat_signed = mode[2];
            ctl.cr_en      = rc;
        end
    end
endmodule

// File: rtl/vff_alu.sv
module vff_alu
    import vff_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  op_kind_t      kind,
    input  logic          sat_signed,
    output logic [DW-1:0] y
);
    localparam logic [DW-1:0] UMAX = {DW{1'b1}};
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0] usum;
    logic [DW:0] ssum;

    always_comb begin
        usum = {1'b0, a} + {1'b0, b};
        ssum = {a[DW-1], a} + {b[DW-1], b};
        y    = usum[DW-1:0];
        if (kind == K_SAT) begin
            if (sat_signed) begin
                if (ssum[DW] != ssum[DW-1])
                    y = ssum[DW] ? SMIN : SMAX;
            end else if (usum[DW]) begin
                y = UMAX;
            end
        end
    end
endmodule

// File: rtl/vff_cond.sv
module vff_cond
    import vff_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] y,
    input  logic          so,
    input  ctl_t          ctl,
    output cond_t         cr,
    output logic          fail
);
    logic tbit;

    always_comb begin
        cr.eq = (y == '0);
        cr.lt = y[DW-1];
        cr.gt = ~cr.lt & ~cr.eq;
        cr.so = so;
        tbit  = pick_cond(cr, ctl.test_sel);
        fail  = (ctl.kind == K_EXIT) && ctl.test_en && (tbit == ctl.invert);
    end
endmodule

// File: rtl/vff_seq.sv
module vff_seq
    import vff_pkg::*;
#(
    parameter int DW  = 8,
    parameter int VLW = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [VLW-1:0] vl_in,
    input  logic [4:0]     mode,
    input  logic           rc,
    input  logic [DW-1:0]  op_a,
    input  logic [DW-1:0]  op_b,
    input  logic           so_in,
    output logic           busy,
    output logic [VLW-1:0] elem_idx,
    output logic [DW-1:0]  res_out,
    output logic           res_we,
    output logic [CR_W-1:0] cr_out,
    output logic           cr_we,
    output logic [VLW-1:0] vl_out,
    output logic           done
);
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_END} st_t;

    st_t            st;
    logic [VLW-1:0] idx_q;
    logic [VLW-1:0] len_q;
    logic [VLW-1:0] vl_q;
    logic [4:0]     mode_q;
    logic           rc_q;

    ctl_t           ctl;
    cond_t          cr;
    logic           elem_fail;
    logic           keep_bit;
    logic           last_elem;

    vff_decode u_dec (
        .mode (mode_q),
        .rc   (rc_q),
        .ctl  (ctl)
    );

    vff_alu #(.DW(DW)) u_alu (
        .a          (op_a),
        .b          (op_b),
        .kind       (ctl.kind),
        .sat_signed (ctl.sat_signed),
        .y          (res_out)
    );

    vff_cond #(.DW(DW)) u_cond (
        .y    (res_out),
        .so   (so_in),
        .ctl  (ctl),
        .cr   (cr),
        .fail (elem_fail)
    );

    assign keep_bit  = ctl.keep_fail;
    assign last_elem = (idx_q == len_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            idx_q  <= '0;
            len_q  <= '0;
            vl_q   <= '0;
            mode_q <= '0;
            rc_q   <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    idx_q  <= '0;
                    len_q  <= vl_in;
                    mode_q <= mode;
                    rc_q   <= rc;
                    if (vl_in == '0) begin
                        vl_q <= '0;
                        st   <= S_END;
                    end else begin
                        st   <= S_RUN;
                    end
                end
                S_RUN: begin
                    if (elem_fail) begin
                        vl_q <= keep_bit ? idx_q + 1'b1 : idx_q;
                        st   <= S_END;
                    end else if (last_elem) begin
                        vl_q <= len_q;
                        st   <= S_END;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (st == S_RUN);
        done     = (st == S_END);
        elem_idx = idx_q;
        vl_out   = vl_q;
        cr_out   = cr;
        res_we   = busy & ~(elem_fail & ~keep_bit);
        cr_we    = busy & ctl.cr_en;
    end
endmodule

// File: rtl/vff_seq_chk.sv
module vff_seq_chk #(
    parameter int VLW = 7
) (
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic           done,
    input logic           res_we,
    input logic           cr_we,
    input logic [VLW-1:0] elem_idx,
    input logic [VLW-1:0] vl_out,
    input logic           elem_fail,
    input logic           keep_bit,
    input logic           rc_q
);
    // R10
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || elem_idx == VLW'($past(elem_idx) + 1'b1)));

    // R10
    end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R11
    quiet_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !res_we && !cr_we));

    // R6
    trunc_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && elem_fail && !keep_bit) |=> (done && vl_out == $past(elem_idx)));

    // R7
    trunc_incl_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && elem_fail && keep_bit) |=> (done && vl_out == VLW'($past(elem_idx) + 1'b1)));

    // R8
    fail_cr_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && elem_fail && rc_q) |-> cr_we);
endmodule

bind vff_seq vff_seq_chk #(.VLW(VLW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .res_we    (res_we),
    .cr_we     (cr_we),
    .elem_idx  (elem_idx),
    .vl_out    (vl_out),
    .elem_fail (elem_fail),
    .keep_bit  (keep_bit),
    .rc_q      (rc_q)
);

// File: tb/vff_seq_bench.sv
module vff_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [6:0] vl_in = '0;
    logic [4:0] mode = '0;
    logic       rc = 1'b0;
    logic [7:0] op_a, op_b;
    logic       so_in;
    logic       busy, res_we, cr_we, done;
    logic [6:0] elem_idx, vl_out;
    logic [7:0] res_out;
    logic [3:0] cr_out;

    logic [7:0] a_mem [128];
    logic [7:0] b_mem [128];
    logic       s_mem [128];

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    assign op_a  = a_mem[elem_idx];
    assign op_b  = b_mem[elem_idx];
    assign so_in = s_mem[elem_idx];

    vff_seq u_vff_seq (
        .clk(clk), .rst(rst), .start(start), .vl_in(vl_in), .mode(mode), .rc(rc),
        .op_a(op_a), .op_b(op_b), .so_in(so_in), .busy(busy), .elem_idx(elem_idx),
        .res_out(res_out), .res_we(res_we), .cr_out(cr_out), .cr_we(cr_we),
        .vl_out(vl_out), .done(done)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            miscompares++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic fill(int p);
        for (int i = 0; i < 128; i++) begin
            case (p)
                0: begin a_mem[i] = 8'(i*29+3);   b_mem[i] = 8'(i*13); s_mem[i] = (i%4 == 3); end
                1: begin a_mem[i] = 8'(i-3);      b_mem[i] = 8'd0;     s_mem[i] = i[0];      end
                2: begin a_mem[i] = 8'd127;       b_mem[i] = 8'(i);    s_mem[i] = 1'b0;      end
                3: begin a_mem[i] = 8'(200+i);    b_mem[i] = 8'd60;    s_mem[i] = 1'b1;      end
                default: begin a_mem[i] = 8'(i*i*7+5); b_mem[i] = 8'(~i*3); s_mem[i] = i[2]; end
            endcase
        end
    endtask

    task automatic model(int i, logic [4:0] md, logic r,
                         output logic [7:0] res, output logic [3:0] cr,
                         output bit rwe, output bit cwe, output bit fl);
        int s;
        logic lt, gt, eq, bitv, act;
        bit ff, sat;
        ff  = md[1];
        sat = !md[1] && md[0];
        if (sat && !md[2]) begin
            s = int'(a_mem[i]) + int'(b_mem[i]);
            res = (s > 255) ? 8'd255 : 8'(s);
        end else if (sat) begin
            s = int'($signed(a_mem[i])) + int'($signed(b_mem[i]));
            res = (s > 127) ? 8'd127 : (s < -128) ? 8'h80 : 8'(s);
        end else begin
            res = 8'(a_mem[i] + b_mem[i]);
        end
        lt = res[7]; eq = (res == 0); gt = !lt && !eq;
        cr = {lt, gt, eq, s_mem[i]};
        if (r) begin act = 1'b1; bitv = cr[3 - {md[3], md[4]}]; end
        else   begin act = md[4]; bitv = eq; end
        fl  = ff && act && (bitv == md[2]);
        rwe = !(fl && !md[0]);
        cwe = r || (ff && md[4]);
    endtask

    task automatic run_case(int vl, logic [4:0] md, logic r, bit noise);
        logic [7:0] er; logic [3:0] ec; bit rwe, cwe, fl, stop;
        int exp_vl;
        string rt, pre;
        pre = noise ? "R13 " : "";
        rt  = md[1] ? "R3" : (md[0] ? (md[2] ? "R2" : "R1") : "R3");
        @(negedge clk);
        vl_in = 7'(vl); mode = md; rc = r; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_vl = vl;
        for (int i = 0; i < vl; i++) begin
            model(i, md, r, er, ec, rwe, cwe, fl);
            chk({pre, md[1] ? "R10 busy" : "R12 busy"}, busy, 1);
            chk({pre, "R10 elem_idx"}, elem_idx, i);
            chk({pre, fl ? (md[0] ? "R7 res_we" : "R6 res_we") : "R3 res_we"}, res_we, rwe);
            if (rwe) chk({pre, rt, " res_out"}, res_out, er);
            chk({pre, r ? "R8 cr_we" : "R9 cr_we"}, cr_we, cwe);
            if (cwe) chk({pre, "R4 cr_out"}, cr_out, ec);
            stop = fl || (i == vl-1);
            if (fl) exp_vl = md[0] ? i+1 : i;
            if (noise && !stop) begin
                start = 1'b1; vl_in = 7'(vl+5); mode = ~md; rc = ~r;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (stop) break;
        end
        start = 1'b0;
        chk({pre, "R10 done"}, done, 1);
        chk({pre, "R11 busy at end"}, busy, 0);
        chk({pre, "R11 strobes at end"}, {res_we, cr_we}, 0);
        chk({pre, (exp_vl != vl) ? (r ? "R5 R6 R7 vl_out" : "R9 R6 R7 vl_out")
                                 : (vl == 0 ? "R11 vl_out" : "R10 R12 vl_out")},
            vl_out, exp_vl);
        @(negedge clk);
        chk({pre, "R10 done width"}, done, 0);
    endtask

    initial begin
        fill(0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset busy", busy, 0);
        chk("R11 reset done", done, 0);
        chk("R11 reset vl_out", vl_out, 0);
        chk("R11 reset strobes", {res_we, cr_we}, 0);
        for (int p = 0; p < 5; p++) begin
            fill(p);
            for (int m = 0; m < 32; m++)
                for (int r = 0; r < 2; r++) begin
                    run_case(0, 5'(m), r[0], 1'b0);
                    run_case(1, 5'(m), r[0], 1'b0);
                    run_case(4, 5'(m), r[0], 1'b0);
                    run_case(9, 5'(m), r[0], 1'b0);
                    run_case(20, 5'(m), r[0], 1'b0);
                end
        end
        fill(0);
        run_case(127, 5'b00000, 1'b1, 1'b0);
        run_case(127, 5'b00001, 1'b0, 1'b1);
        fill(1);
        run_case(20, 5'b10010, 1'b0, 1'b1);
        run_case(20, 5'b10011, 1'b0, 1'b1);
        run_case(0, 5'b00010, 1'b1, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule